// File: doc/BRIEF.md
# Conditional Branch Target Unit

This unit settles whether a relative branch is taken and where it lands. Each request carries a four-bit branch class, the N, V, Z and C condition flags, a memory operand with a selection mask, the address of the next instruction, the current bank value and a signed displacement. The result appears one clock later as a taken indication, the new program counter and the new bank value.

There are three kinds of branch. Flag branches test a single condition flag. The unconditional branch is always taken. The two bit-test branches take the jump only when every bit that the mask selects in the memory operand has the required value. A taken branch adds the sign-extended displacement to the next-instruction address. When that sum leaves the 16-bit address range, the bank value steps up on an overflow past the top and steps down on an underflow below zero. A branch that is not taken passes the next-instruction address through and leaves the bank untouched.

The unit is pure decision and arithmetic logic followed by one result register. Operand and mask fetch happen upstream.

Top module: `branch_target_unit`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the outputs clear after that edge: `res_valid`, `res_taken`, `res_pc` and `res_bank` all become 0. This holds even if `req_valid` is high.
- R2: A request sampled with `req_valid` high at a rising edge produces its result on the outputs after that same edge, and `res_valid` is high for exactly that one cycle. At an edge where `req_valid` is low, `res_valid` goes low and `res_taken`, `res_pc` and `res_bank` keep their values.
- R3: Class 0 (carry clear) is taken when C is 0. Class 1 (carry set) is taken when C is 1.
- R4: Class 2 (equal) is taken when Z is 1. Class 3 (not equal) is taken when Z is 0.
- R5: Class 4 is taken when N is 1 and class 5 when N is 0. Class 6 is taken when V is 0 and class 7 when V is 1.
- R6: Class 8 is always taken, whatever the flags are.
- R7: Class 9 is taken only when `mem_operand & bit_mask` has no bit set. Class 10 is taken only when every bit set in `bit_mask` is also set in `mem_operand`. An empty selection makes both classes taken.
- R8: When `narrow` is 1, only bits 7:0 of `bit_mask` and `mem_operand` take part in the test for classes 9 and 10. Bits 15:8 then have no effect.
- R9: Classes 11 to 15 are never taken. They follow the not-taken rule of R12.
- R10: For a taken branch, `res_pc` = (`next_pc` + `offset`) mod 2^16, where `offset` is an 8-bit two's-complement value.
- R11: For a taken branch, `res_bank` = `bank_in` + 1 when the signed sum is 2^16 or more, and `bank_in` − 1 when the sum is below 0. Both cases wrap modulo 2^8. Otherwise `res_bank` = `bank_in`.
- R12: For a branch that is not taken, `res_pc` = `next_pc` and `res_bank` = `bank_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 4 | Branch class (codes in R3 to R9) |
| flag_n | input | 1 | Negative flag |
| flag_v | input | 1 | Overflow flag |
| flag_z | input | 1 | Zero flag |
| flag_c | input | 1 | Carry flag |
| narrow | input | 1 | Byte-wide bit test when 1 |
| mem_operand | input | 16 | Memory operand for bit-test classes |
| bit_mask | input | 16 | Selects the operand bits to test |
| next_pc | input | 16 | Address of the following instruction |
| bank_in | input | 8 | Current bank value |
| offset | input | 8 | Signed displacement |
| res_valid | output | 1 | Result strobe |
| res_taken | output | 1 | Branch taken |
| res_pc | output | 16 | New program counter |
| res_bank | output | 8 | New bank value |

## Verification
Every class from 0 to 15 is applied with all sixteen flag combinations. This separates each flag branch from its complement and from the always-taken and reserved classes. The bit-test classes get empty, full and partial masks against all-zero, all-one and mixed operands, plus narrow-mode cases whose upper byte would change the outcome. Together these separate "every selected bit" from "any selected bit" and show where the narrow cut-off lies. Targets are aimed just past the top of the address range, just below zero and at bank values 0x00 and 0xFF, which separates increment, decrement, no change and wrap. Idle cycles placed between requests show that the outputs hold.

// File: rtl/bct_pkg.sv
// Package bct_pkg
// Shared encodings for the branch target unit: branch class codes and the
// condition flag bundle. Class codes 11..15 are reserved and never taken.
package bct_pkg;

    typedef enum logic [3:0] {
        BR_C_CLR    = 4'd0,
        BR_C_SET    = 4'd1,
        BR_Z_SET    = 4'd2,
        BR_Z_CLR    = 4'd3,
        BR_N_SET    = 4'd4,
        BR_N_CLR    = 4'd5,
        BR_V_CLR    = 4'd6,
        BR_V_SET    = 4'd7,
        BR_ALWAYS   = 4'd8,
        BR_BITS_CLR = 4'd9,
        BR_BITS_SET = 4'd10
    } br_op_e;

    typedef struct packed {
        logic n;
        logic v;
        logic z;
        logic c;
    } flags_t;

    localparam int unsigned OP_W = 4;

endpackage

// File: rtl/bct_flag_cond.sv
// Module bct_flag_cond
// Evaluates the flag-based branch classes and the unconditional class.
// Assumes: op is the raw class code; bit-test and reserved codes give 0 here.
module bct_flag_cond
    import bct_pkg::*;
(
    input  logic [OP_W-1:0] op,
    input  flags_t          flags,
    output logic            cond_hit
);

    // Map each flag class onto its single-flag test.
    always_comb begin
        case (op)
            BR_C_CLR:  cond_hit = ~flags.c;
            BR_C_SET:  cond_hit =  flags.c;
            BR_Z_SET:  cond_hit =  flags.z;
            BR_Z_CLR:  cond_hit = ~flags.z;
            BR_N_SET:  cond_hit =  flags.n;
            BR_N_CLR:  cond_hit = ~flags.n;
            BR_V_CLR:  cond_hit = ~flags.v;
            BR_V_SET:  cond_hit =  flags.v;
            BR_ALWAYS: cond_hit = 1'b1;
            default:   cond_hit = 1'b0;
        endcase
    end

endmodule

// File: rtl/bct_bit_test.sv
// Module bct_bit_test
// Tests the mask-selected bits of a memory operand: reports whether all of
// them are 0 and whether all of them are 1. In narrow mode only the low half
// of the operand and mask takes part.
// Assumes: DATA_W is even; an empty selection satisfies both tests.
module bct_bit_test #(
    parameter int unsigned DATA_W = 16
) (
    input  logic              narrow,
    input  logic [DATA_W-1:0] operand,
    input  logic [DATA_W-1:0] mask,
    output logic              all_clear,
    output logic              all_set
);

    localparam int unsigned HALF_W = DATA_W / 2;

    logic [DATA_W-1:0] sel;

    // Build the effective selection, dropping the upper half in narrow mode.
    for (genvar i = 0; i < DATA_W; i++) begin : g_sel
        if (i < HALF_W) begin : g_low
            assign sel[i] = mask[i];
        end else begin : g_high
            assign sel[i] = mask[i] & ~narrow;
        end
    end

    // Reduce the selected bits into the two match results.
    always_comb begin
        all_clear = ~|(sel & operand);
        all_set   = ~|(sel & ~operand);
    end

endmodule

// File: rtl/bct_rel_target.sv
// Module bct_rel_target
// Adds a sign-extended displacement to the next-instruction address. An
// overflow past the top of the address range steps the bank up; an
// underflow below zero steps it down.
// Assumes: OFF_W < PC_W; the bank wraps modulo 2^BANK_W.
module bct_rel_target #(
    parameter int unsigned PC_W   = 16,
    parameter int unsigned BANK_W = 8,
    parameter int unsigned OFF_W  = 8
) (
    input  logic [PC_W-1:0]   base_pc,
    input  logic [BANK_W-1:0] base_bank,
    input  logic [OFF_W-1:0]  disp,
    output logic [PC_W-1:0]   tgt_pc,
    output logic [BANK_W-1:0] tgt_bank
);

    localparam int unsigned SUM_W = PC_W + 2;
    localparam int unsigned EXT_W = SUM_W - OFF_W;

    logic [SUM_W-1:0] disp_ext;
    logic [SUM_W-1:0] sum;
    logic             over_top;
    logic             under_zero;

    // Sign-extend the displacement and form the two-bit-wider sum.
    always_comb begin
        disp_ext = {{EXT_W{disp[OFF_W-1]}}, disp};
        sum      = {2'b00, base_pc} + disp_ext;
    end

    // Decode the out-of-range cases from the two guard bits.
    always_comb begin
        over_top   = (sum[SUM_W-1:PC_W] == 2'b01);
        under_zero = (sum[SUM_W-1:PC_W] == 2'b11);
    end

    // Produce the wrapped address and the adjusted bank.
    always_comb begin
        tgt_pc = sum[PC_W-1:0];
        if (over_top) begin
            tgt_bank = base_bank + BANK_W'(1);
        end else if (under_zero) begin
            tgt_bank = base_bank - BANK_W'(1);
        end else begin
            tgt_bank = base_bank;
        end
    end

endmodule

// File: rtl/branch_target_unit.sv
// Module branch_target_unit
// Top of the conditional branch target unit. Combines the flag decision, the
// memory bit test and the relative target adder, then registers the outcome
// for one cycle. Assumes next_pc already points past the branch instruction.
module branch_target_unit
    import bct_pkg::*;
#(
    parameter int unsigned PC_W   = 16,
    parameter int unsigned BANK_W = 8,
    parameter int unsigned OFF_W  = 8,
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [3:0]        req_op,
    input  logic              flag_n,
    input  logic              flag_v,
    input  logic              flag_z,
    input  logic              flag_c,
    input  logic              narrow,
    input  logic [DATA_W-1:0] mem_operand,
    input  logic [DATA_W-1:0] bit_mask,
    input  logic [PC_W-1:0]   next_pc,
    input  logic [BANK_W-1:0] bank_in,
    input  logic [OFF_W-1:0]  offset,
    output logic              res_valid,
    output logic              res_taken,
    output logic [PC_W-1:0]   res_pc,
    output logic [BANK_W-1:0] res_bank
);

    flags_t            flags;
    logic              cond_hit;
    logic              all_clear;
    logic              all_set;
    logic              take;
    logic [PC_W-1:0]   tgt_pc;
    logic [BANK_W-1:0] tgt_bank;

    // Bundle the individual flag pins.
    always_comb flags = '{n: flag_n, v: flag_v, z: flag_z, c: flag_c};

    bct_flag_cond u_flag_cond (
        .op       (req_op),
        .flags    (flags),
        .cond_hit (cond_hit)
    );

    bct_bit_test #(.DATA_W(DATA_W)) u_bit_test (
        .narrow    (narrow),
        .operand   (mem_operand),
        .mask      (bit_mask),
        .all_clear (all_clear),
        .all_set   (all_set)
    );

    bct_rel_target #(.PC_W(PC_W), .BANK_W(BANK_W), .OFF_W(OFF_W)) u_rel_target (
        .base_pc   (next_pc),
        .base_bank (bank_in),
        .disp      (offset),
        .tgt_pc    (tgt_pc),
        .tgt_bank  (tgt_bank)
    );

    // Merge the flag decision with the two bit-test classes.
    always_comb begin
        take = cond_hit
             | ((req_op == BR_BITS_CLR) & all_clear)
             | ((req_op == BR_BITS_SET) & all_set);
    end

    // Register the outcome; hold it while no request is presented.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            res_taken <= 1'b0;
            res_pc    <= '0;
            res_bank  <= '0;
        end else begin
            res_valid <= req_valid;
            if (req_valid) begin
                res_taken <= take;
                res_pc    <= take ? tgt_pc : next_pc;
                res_bank  <= take ? tgt_bank : bank_in;
            end
        end
    end

    // R1: reset clears every output
    p_reset_clears_r1: assert property (@(posedge clk)
        !rst_n |=> (!res_valid && !res_taken && res_pc == '0 && res_bank == '0));

    // R2: a sampled request yields the strobe one edge later
    p_result_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> res_valid);

    // R2: idle cycles drop the strobe and hold the result
    p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!res_valid && $stable(res_taken) && $stable(res_pc) && $stable(res_bank)));

    // R6: the unconditional class is always taken
    p_always_taken_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == BR_ALWAYS) |=> res_taken);

    // R9: reserved classes are never taken
    p_reserved_never_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op > BR_BITS_SET) |=> !res_taken);

    // R11: the bank moves by at most one step
    p_bank_step_r11: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (res_bank == $past(bank_in)
                    || res_bank == BANK_W'($past(bank_in) + BANK_W'(1))
                    || res_bank == BANK_W'($past(bank_in) - BANK_W'(1))));

    // R11: a forward displacement never borrows from the bank
    p_forward_no_borrow_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !offset[OFF_W-1]) |=> (res_bank != BANK_W'($past(bank_in) - BANK_W'(1))));

    // R12: a branch not taken passes the address and bank through
    p_not_taken_pass_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !take) |=> (res_pc == $past(next_pc) && res_bank == $past(bank_in)));

endmodule

// File: tb/branch_target_unit_bench.sv
// Bench for branch_target_unit: a behavioural reference model predicts the
// registered outputs and is compared against the design on every clock.
module branch_target_unit_bench;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic [3:0]  req_op;
    logic        flag_n, flag_v, flag_z, flag_c;
    logic        narrow;
    logic [15:0] mem_operand;
    logic [15:0] bit_mask;
    logic [15:0] next_pc;
    logic [7:0]  bank_in;
    logic [7:0]  offset;
    logic        res_valid;
    logic        res_taken;
    logic [15:0] res_pc;
    logic [7:0]  res_bank;

    int checks = 0;
    int errors = 0;

    // Model state: expected outputs after the next edge.
    logic        e_valid = 1'b0, e_taken = 1'b0;
    logic [15:0] e_pc = '0;
    logic [7:0]  e_bank = '0;
    string       tag_taken = "R1";

    always #4 clk = ~clk;

    branch_target_unit u_branch_target_unit (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .flag_n(flag_n), .flag_v(flag_v), .flag_z(flag_z), .flag_c(flag_c),
        .narrow(narrow), .mem_operand(mem_operand), .bit_mask(bit_mask),
        .next_pc(next_pc), .bank_in(bank_in), .offset(offset),
        .res_valid(res_valid), .res_taken(res_taken), .res_pc(res_pc), .res_bank(res_bank)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    // Compare every output with the model.
    task automatic compare_all(input string hold_tag);
        check("R2", "res_valid", int'(res_valid), int'(e_valid));
        check(e_valid ? tag_taken : hold_tag, "res_taken", int'(res_taken), int'(e_taken));
        if (!e_valid)
            check(hold_tag, "res_pc", int'(res_pc), int'(e_pc));
        else
            check(e_taken ? "R10" : "R12", "res_pc", int'(res_pc), int'(e_pc));
        if (!e_valid)
            check(hold_tag, "res_bank", int'(res_bank), int'(e_bank));
        else
            check(e_taken ? "R11" : "R12", "res_bank", int'(res_bank), int'(e_bank));
    endtask

    // Behavioural prediction of one request.
    task automatic predict();
        bit tk;
        bit any_one, any_zero;
        int sum, off_s, lim;
        if (!req_valid) begin
            e_valid = 1'b0;
            return;
        end
        any_one = 0; any_zero = 0;
        lim = narrow ? 8 : 16;
        for (int i = 0; i < lim; i++) begin
            if (bit_mask[i]) begin
                if (mem_operand[i]) any_one = 1; else any_zero = 1;
            end
        end
        case (req_op)
            4'd0:  begin tk = !flag_c; tag_taken = "R3"; end
            4'd1:  begin tk =  flag_c; tag_taken = "R3"; end
            4'd2:  begin tk =  flag_z; tag_taken = "R4"; end
            4'd3:  begin tk = !flag_z; tag_taken = "R4"; end
            4'd4:  begin tk =  flag_n; tag_taken = "R5"; end
            4'd5:  begin tk = !flag_n; tag_taken = "R5"; end
            4'd6:  begin tk = !flag_v; tag_taken = "R5"; end
            4'd7:  begin tk =  flag_v; tag_taken = "R5"; end
            4'd8:  begin tk = 1;       tag_taken = "R6"; end
            4'd9:  begin tk = !any_one;  tag_taken = narrow ? "R8" : "R7"; end
            4'd10: begin tk = !any_zero; tag_taken = narrow ? "R8" : "R7"; end
            default: begin tk = 0;     tag_taken = "R9"; end
        endcase
        e_valid = 1'b1;
        e_taken = tk;
        if (tk) begin
            off_s = (offset >= 8'd128) ? int'(offset) - 256 : int'(offset);
            sum = int'(next_pc) + off_s;
            e_pc = 16'((sum + 65536) % 65536);
            if (sum > 65535)   e_bank = bank_in + 8'd1;
            else if (sum < 0)  e_bank = bank_in - 8'd1;
            else               e_bank = bank_in;
        end else begin
            e_pc = next_pc;
            e_bank = bank_in;
        end
    endtask

    // Drive one cycle of stimulus at a falling edge and check at the next.
    task automatic step(input bit v, input int op, input int fl, input bit nar,
                        input int mem, input int msk, input int pc, input int bk, input int off);
        req_valid = v; req_op = 4'(op);
        {flag_n, flag_v, flag_z, flag_c} = 4'(fl);
        narrow = nar; mem_operand = 16'(mem); bit_mask = 16'(msk);
        next_pc = 16'(pc); bank_in = 8'(bk); offset = 8'(off);
        predict();
        @(negedge clk);
        compare_all("R2");
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL R2 watchdog actual running expected finished");
        summary();
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        req_valid = 1'b1; req_op = 4'd8;
        {flag_n, flag_v, flag_z, flag_c} = 4'hF;
        narrow = 0; mem_operand = '1; bit_mask = '1;
        next_pc = 16'h1234; bank_in = 8'h55; offset = 8'h10;
        repeat (3) @(negedge clk);
        // R1: reset wins over a pending request
        check("R1", "res_valid", int'(res_valid), 0);
        check("R1", "res_taken", int'(res_taken), 0);
        check("R1", "res_pc", int'(res_pc), 0);
        check("R1", "res_bank", int'(res_bank), 0);
        rst_n = 1'b1;
        req_valid = 1'b0;
        @(negedge clk);
        compare_all("R1");

        // R3..R6, R9: every class against every flag pattern
        for (int op = 0; op < 16; op++) begin
            for (int fl = 0; fl < 16; fl++) begin
                step(1, op, fl, 0, 16'h00F0, 16'h0F00, 16'h4000 + op * 16, 8'h20 + fl, 8'h40 + fl);
            end
            step(0, op, 0, 0, 0, 0, 16'hDEAD, 8'h11, 8'h01); // R2 idle hold
        end

        // R10, R11: carry into the bank, borrow from it, and wrap
        step(1, 8, 0, 0, 0, 0, 16'hFFF0, 8'h10, 8'h7F);
        step(1, 8, 0, 0, 0, 0, 16'h0005, 8'h10, 8'h80);
        step(1, 8, 0, 0, 0, 0, 16'hFFFF, 8'hFF, 8'h01);
        step(1, 8, 0, 0, 0, 0, 16'h0000, 8'h00, 8'hFF);
        step(1, 8, 0, 0, 0, 0, 16'hFF80, 8'h33, 8'h7F);
        step(1, 8, 0, 0, 0, 0, 16'h0080, 8'h33, 8'h80);
        step(1, 8, 0, 0, 0, 0, 16'h8000, 8'h33, 8'h00);
        // R12: not-taken branch near the edge keeps the bank
        step(1, 1, 0, 0, 0, 0, 16'hFFFF, 8'hFF, 8'h7F);
        step(0, 1, 0, 0, 0, 0, 16'h0000, 8'h00, 8'h80);

        // R7: bit tests with empty, full and partial selections
        for (int op = 9; op <= 10; op++) begin
            step(1, op, 0, 0, 16'h0000, 16'h0000, 16'h2000, 8'h01, 8'h04);
            step(1, op, 0, 0, 16'hFFFF, 16'h0000, 16'h2000, 8'h01, 8'h04);
            step(1, op, 0, 0, 16'h0000, 16'hFFFF, 16'h2000, 8'h01, 8'h04);
            step(1, op, 0, 0, 16'hFFFF, 16'hFFFF, 16'h2000, 8'h01, 8'h04);
            step(1, op, 0, 0, 16'hA5A5, 16'hA5A5, 16'h2000, 8'h01, 8'hFC);
            step(1, op, 0, 0, 16'hA5A5, 16'h5A5A, 16'h2000, 8'h01, 8'hFC);
            step(1, op, 0, 0, 16'hA5A4, 16'hA5A5, 16'h2000, 8'h01, 8'hFC);
            step(1, op, 0, 0, 16'h0001, 16'h8001, 16'h2000, 8'h01, 8'hFC);
            // R8: upper byte would decide the outcome without narrow mode
            step(1, op, 0, 1, 16'h0F00, 16'hFF0F, 16'h3000, 8'h02, 8'h08);
            step(1, op, 0, 1, 16'hF00F, 16'hFF0F, 16'h3000, 8'h02, 8'h08);
            step(1, op, 0, 0, 16'hF00F, 16'hFF0F, 16'h3000, 8'h02, 8'h08);
            step(1, op, 0, 1, 16'h00FF, 16'hFFFF, 16'h3000, 8'h02, 8'h08);
        end

        // Mixed random traffic with idle gaps
        for (int k = 0; k < 3000; k++) begin
            step(($urandom % 4) != 0, int'($urandom % 16), int'($urandom % 16), bit'($urandom % 2),
                 int'($urandom % 65536), int'(($urandom % 3 == 0) ? 0 : $urandom % 65536),
                 int'($urandom % 65536), int'($urandom % 256), int'($urandom % 256));
        end

        summary();
        $finish;
    end

endmodule